// File: doc/BRIEF.md
# Dual-Law Voice Companding Converter

This block sits between a voice channel's linear sample path and its 8-bit serial PCM slot. In the transmit direction it takes one 14-bit signed linear sample on each frame strobe and turns it into an 8-bit companded code. The code is held in an output register until the next strobe, so the serial shifter can send it during the following frame's slot. In the receive direction it takes an 8-bit code on each receive strobe and expands it into a 14-bit signed linear value for a DAC. The value is held until the next receive strobe.

A static input picks the companding law, mu-law or A-law, for both directions at once. The code MSB is the sign and is the first bit on the wire. A-law codes leave the block with the even bits inverted, and received A-law codes are expected in that same form. Some receive frames borrow the code LSB for signalling. For those frames, a mode input makes the expander treat the lost bit as half a step instead of trusting its value.

Top module: `pcm_law_codec`

## Requirements
- R1: While reset is asserted, tx_code reads 8'hFF when law_sel=0 (mu-law) and 8'hD5 when law_sel=1 (A-law). rx_lin reads 0.
- R2: Mu-law encode, law_sel=0. Let M=|x|, clipped to 8158. Add 33, giving B. The segment S (0..7) is the position of the leading one of B minus 5. The step is B bits S+4..S+1. The code is the bitwise inverse of {sign, S[2:0], step}, where sign=1 for a negative x. Bit 7 of the code is the sign bit.
- R3: Mu-law saturation. Any x above +8158 encodes as 8'h80. x=-8192 encodes as 8'h00.
- R4: A-law encode, law_sel=1. Let a = x>>>1. M=a for a non-negative a and M=~a for a negative a, giving 0..4095. Below 32, S=0 and step=M[4:1]. Otherwise S = leading-one position minus 4 and step = M[S+3:S]. The code is {sign bit (1 for non-negative), S, step} XOR 8'h55.
- R5: A-law full scale. x=+8191 encodes as 8'hAA and x=-8192 encodes as 8'h2A.
- R6: tx_code takes a new value only at a clock edge with tx_strobe=1, one cycle after that edge. Otherwise it holds its value whatever tx_lin does.
- R7: Mu-law decode. With c = ~code, S = c[6:4], T = c[3:0] and L = 2T+33, the magnitude is (L<<S)-33. The value is negative when c[7]=1.
- R8: A-law decode. With p = code^8'h55, S = p[6:4], T = p[3:0] and L = 2T+33, M = L-32 for S=0 and L<<(S-1) otherwise. The output is +2M when p[7]=1 and -2M when p[7]=0.
- R9: With rx_half_lsb=1, the code LSB has no effect. L becomes 2*(T with bit 0 cleared)+34, which is the centre of the two candidate intervals. This applies to both laws.
- R10: rx_lin takes a new value only at a clock edge with rx_strobe=1, one cycle after that edge. Otherwise it holds its value.
- R11: The same linear input gives the mu-law code when law_sel=0 and the A-law code when law_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | Static law select: 0 mu-law, 1 A-law |
| tx_strobe | input | 1 | Frame strobe; captures and encodes tx_lin |
| tx_lin | input | 14 | Signed linear sample to encode |
| tx_code | output | 8 | Buffered companded code, sign bit in MSB |
| rx_strobe | input | 1 | Receive strobe; captures and expands rx_code |
| rx_code | input | 8 | Received companded code |
| rx_half_lsb | input | 1 | Received LSB carries signalling; decode it as half a step |
| rx_lin | output | 14 | Signed linear value from the last expanded code |

## Verification
Any fault in the encode or expand datapath shows up at the output register in the cycle after the strobe that exercised it. It can be seen there as a wrong segment, step or sign. A fault in the hold logic shows up as a change in tx_code or rx_lin on any later cycle without a strobe. The vectors sit on segment edges, zeros of both signs, clip points and LSB pairs in half-step mode, because an off-by-one shift or a misplaced bias changes the result exactly at those points.

// File: rtl/pcm_law_pkg.sv
package pcm_law_pkg;

   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   localparam int unsigned CODE_W = 8;
   localparam int unsigned SEG_W  = 3;
   localparam int unsigned STEP_W = 4;
   localparam int unsigned LVL_W  = STEP_W + 2;

   localparam logic [CODE_W-1:0] A_EVEN_MASK = 8'h55;
   localparam logic [CODE_W-1:0] MU_IDLE     = 8'hFF;
   localparam logic [CODE_W-1:0] A_IDLE      = 8'hD5;

endpackage

// File: rtl/pcm_seg_find.sv
module pcm_seg_find #(
   parameter  int unsigned W  = 8,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits_i,
   output logic [IW-1:0] idx_o,
   output logic          found_o
);

   if (W < 2) begin : g_bad_width
      $error("pcm_seg_find: W must be at least 2");
   end

   logic [W-1:0] lead;

   for (genvar g = 0; g < W; g++) begin : g_bit
      if (g == W - 1) begin : g_top
         assign lead[g] = bits_i[g];
      end else begin : g_low
         assign lead[g] = bits_i[g] & ~(|bits_i[W-1:g+1]);
      end
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (lead[i]) idx_o = IW'(i);
      end
   end

   assign found_o = |bits_i;

endmodule

// File: rtl/pcm_mu_enc.sv
module pcm_mu_enc
   import pcm_law_pkg::*;
#(
   parameter  int unsigned LIN_W   = 14,
   parameter  int unsigned MU_CLIP = 8158,
   parameter  int unsigned MU_BIAS = 33,
   localparam int unsigned MAG_W   = LIN_W - 1,
   localparam int unsigned SEGS    = 1 << SEG_W,
   localparam int unsigned LOW_BIT = MAG_W - SEGS
) (
   input  logic signed [LIN_W-1:0] lin_i,
   output logic [CODE_W-1:0]       code_o
);

   if (MU_BIAS != (1 << LOW_BIT) + 1) begin : g_bad_bias
      $error("pcm_mu_enc: bias must be one above the lowest segment bit");
   end
   if (MU_CLIP + MU_BIAS >= (1 << MAG_W)) begin : g_bad_clip
      $error("pcm_mu_enc: clip plus bias must fit the magnitude width");
   end

   logic                 neg;
   logic signed [LIN_W:0] ext;
   logic [LIN_W:0]       absv;
   logic [MAG_W-1:0]     clipped;
   logic [MAG_W-1:0]     biased;
   logic [SEG_W-1:0]     seg;
   logic                 seg_hit;
   logic [STEP_W-1:0]    step;

   assign neg     = lin_i[LIN_W-1];
   assign ext     = {lin_i[LIN_W-1], lin_i};
   assign absv    = neg ? unsigned'(-ext) : unsigned'(ext);
   assign clipped = (absv > (LIN_W+1)'(MU_CLIP)) ? MAG_W'(MU_CLIP) : MAG_W'(absv);
   assign biased  = clipped + MAG_W'(MU_BIAS);

   pcm_seg_find #(.W(SEGS)) u_seg (
      .bits_i  (biased[MAG_W-1:LOW_BIT]),
      .idx_o   (seg),
      .found_o (seg_hit)
   );

   assign step   = STEP_W'(biased >> ({1'b0, seg} + 4'(LOW_BIT - STEP_W)));
   assign code_o = ~{neg, seg, step};

endmodule

// File: rtl/pcm_a_enc.sv
module pcm_a_enc
   import pcm_law_pkg::*;
#(
   parameter  int unsigned LIN_W = 14,
   parameter  int unsigned DROP  = 1,
   localparam int unsigned AW    = LIN_W - DROP,
   localparam int unsigned MAG_W = AW - 1,
   localparam int unsigned SEGS  = (1 << SEG_W) - 1,
   localparam int unsigned LOW_BIT = MAG_W - SEGS
) (
   input  logic signed [LIN_W-1:0] lin_i,
   output logic [CODE_W-1:0]       code_o
);

   if (LOW_BIT != STEP_W + 1) begin : g_bad_width
      $error("pcm_a_enc: magnitude width does not give a 5-bit linear segment");
   end

   logic signed [AW-1:0] a;
   logic                 neg;
   logic [MAG_W-1:0]     mag;
   logic [SEG_W-1:0]     hi_idx;
   logic                 hi_hit;
   logic [SEG_W-1:0]     seg;
   logic [SEG_W-1:0]     shift;
   logic [STEP_W-1:0]    step;

   assign a   = AW'(lin_i >>> DROP);
   assign neg = lin_i[LIN_W-1];
   assign mag = MAG_W'(neg ? ~a : a);

   pcm_seg_find #(.W(SEGS)) u_seg (
      .bits_i  (mag[MAG_W-1:LOW_BIT]),
      .idx_o   (hi_idx),
      .found_o (hi_hit)
   );

   assign seg    = hi_hit ? hi_idx + 3'd1 : 3'd0;
   assign shift  = hi_hit ? seg : 3'd1;
   assign step   = STEP_W'(mag >> shift);
   assign code_o = {~neg, seg, step} ^ A_EVEN_MASK;

endmodule

// File: rtl/pcm_expand.sv
module pcm_expand
   import pcm_law_pkg::*;
#(
   parameter  int unsigned LIN_W = 14,
   localparam int unsigned MAG_W = LIN_W - 1
) (
   input  logic                    law_i,
   input  logic                    half_i,
   input  logic [CODE_W-1:0]       code_i,
   output logic signed [LIN_W-1:0] lin_o
);

   if (LIN_W != 14) begin : g_bad_width
      $error("pcm_expand: level arithmetic is sized for 14-bit samples");
   end

   logic [CODE_W-1:0] pre;
   logic              neg;
   logic [SEG_W-1:0]  seg;
   logic [STEP_W-1:0] step;
   logic [LVL_W-1:0]  lvl;
   logic [MAG_W-1:0]  mu_mag;
   logic [MAG_W-1:0]  a_half;
   logic [MAG_W-1:0]  mag;
   logic signed [LIN_W-1:0] pos;

   assign pre  = (law_i == LAW_A) ? (code_i ^ A_EVEN_MASK) : ~code_i;
   assign neg  = (law_i == LAW_A) ? ~pre[CODE_W-1] : pre[CODE_W-1];
   assign seg  = pre[CODE_W-2 -: SEG_W];
   assign step = pre[STEP_W-1:0];

   // centre of one interval, or of the LSB pair when the LSB is lost
   assign lvl = half_i ? ({1'b0, step[STEP_W-1:1], 2'b00} + LVL_W'(34))
                       : ({1'b0, step, 1'b1} + LVL_W'(32));

   assign mu_mag = (MAG_W'(lvl) << seg) - MAG_W'(33);
   assign a_half = (seg == '0) ? (MAG_W'(lvl) - MAG_W'(32))
                               : (MAG_W'(lvl) << (seg - 3'd1));
   assign mag    = (law_i == LAW_A) ? {a_half[MAG_W-2:0], 1'b0} : mu_mag;

   assign pos   = signed'({1'b0, mag});
   assign lin_o = neg ? -pos : pos;

endmodule

// File: rtl/pcm_law_codec.sv
module pcm_law_codec
   import pcm_law_pkg::*;
#(
   parameter int unsigned LIN_W        = 14,
   parameter int unsigned MU_CLIP      = 8158,
   parameter int unsigned MU_BIAS      = 33,
   parameter bit          HALF_STEP_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    law_sel,
   input  logic                    tx_strobe,
   input  logic signed [LIN_W-1:0] tx_lin,
   output logic [CODE_W-1:0]       tx_code,
   input  logic                    rx_strobe,
   input  logic [CODE_W-1:0]       rx_code,
   input  logic                    rx_half_lsb,
   output logic signed [LIN_W-1:0] rx_lin
);

   if (LIN_W != 14) begin : g_bad_width
      $error("pcm_law_codec: only 14-bit linear samples are supported");
   end

   logic [CODE_W-1:0]       mu_code;
   logic [CODE_W-1:0]       a_code;
   logic [CODE_W-1:0]       enc_code;
   logic                    half_eff;
   logic signed [LIN_W-1:0] dec_lin;

   pcm_mu_enc #(
      .LIN_W   (LIN_W),
      .MU_CLIP (MU_CLIP),
      .MU_BIAS (MU_BIAS)
   ) u_mu_enc (
      .lin_i  (tx_lin),
      .code_o (mu_code)
   );

   pcm_a_enc #(
      .LIN_W (LIN_W),
      .DROP  (1)
   ) u_a_enc (
      .lin_i  (tx_lin),
      .code_o (a_code)
   );

   assign enc_code = (law_sel == LAW_A) ? a_code : mu_code;

   if (HALF_STEP_EN) begin : g_half_on
      assign half_eff = rx_half_lsb;
   end else begin : g_half_off
      logic unused_half;
      assign unused_half = rx_half_lsb;
      assign half_eff    = 1'b0;
   end

   pcm_expand #(.LIN_W(LIN_W)) u_expand (
      .law_i  (law_sel),
      .half_i (half_eff),
      .code_i (rx_code),
      .lin_o  (dec_lin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code <= (law_sel == LAW_A) ? A_IDLE : MU_IDLE;
      end else if (tx_strobe) begin
         tx_code <= enc_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lin <= '0;
      end else if (rx_strobe) begin
         rx_lin <= dec_lin;
      end
   end

endmodule

// File: rtl/pcm_law_codec_chk.sv
module pcm_law_codec_chk #(
   parameter int unsigned LIN_W = 14
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    law_sel,
   input logic                    tx_strobe,
   input logic signed [LIN_W-1:0] tx_lin,
   input logic [7:0]              tx_code,
   input logic                    rx_strobe,
   input logic [7:0]              rx_code,
   input logic                    rx_half_lsb,
   input logic signed [LIN_W-1:0] rx_lin
);

   logic unused_half;
   assign unused_half = rx_half_lsb;

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_strobe |=> $stable(tx_code));

   // R10
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_strobe |=> $stable(rx_lin));

   // R3
   mu_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_strobe && !law_sel && (tx_lin > 14'sd8158)) |=> (tx_code == 8'h80));

   // R5
   a_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_strobe && law_sel && (tx_lin == -14'sd8192)) |=> (tx_code == 8'h2A));

   // R7
   mu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && !law_sel && rx_code[7]) |=> !rx_lin[LIN_W-1]);

   // R8
   a_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && law_sel && !rx_code[7]) |=> rx_lin[LIN_W-1]);

endmodule

bind pcm_law_codec pcm_law_codec_chk #(.LIN_W(LIN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .law_sel     (law_sel),
   .tx_strobe   (tx_strobe),
   .tx_lin      (tx_lin),
   .tx_code     (tx_code),
   .rx_strobe   (rx_strobe),
   .rx_code     (rx_code),
   .rx_half_lsb (rx_half_lsb),
   .rx_lin      (rx_lin)
);

// File: tb/pcm_law_codec_bench.sv
module pcm_law_codec_bench;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              law_sel = 1'b0;
   logic              tx_strobe = 1'b0;
   logic signed [13:0] tx_lin = '0;
   logic [7:0]        tx_code;
   logic              rx_strobe = 1'b0;
   logic [7:0]        rx_code = '0;
   logic              rx_half_lsb = 1'b0;
   logic signed [13:0] rx_lin;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pcm_law_codec u_pcm_law_codec (
      .clk (clk), .rst_n (rst_n), .law_sel (law_sel),
      .tx_strobe (tx_strobe), .tx_lin (tx_lin), .tx_code (tx_code),
      .rx_strobe (rx_strobe), .rx_code (rx_code),
      .rx_half_lsb (rx_half_lsb), .rx_lin (rx_lin)
   );

   // {decode, law, half, lin[13:0], code[7:0]}
   function automatic logic [24:0] mk(bit dec, bit law, bit half, int lin, logic [7:0] code);
      return {dec, law, half, 14'(lin), code};
   endfunction

   localparam int NV = 32;
   localparam logic [24:0] VEC [NV] = '{
      mk(0,0,0,    0,8'hFF), mk(0,0,0,   -1,8'h7E), mk(0,0,0,  100,8'hDF),
      mk(0,0,0,-1000,8'h2F), mk(0,0,0,   30,8'hF0),
      mk(0,1,0,    0,8'hD5), mk(0,1,0,   -1,8'h55), mk(0,1,0,  100,8'hCC),
      mk(0,1,0,-1000,8'h1A), mk(0,1,0,   62,8'hDA), mk(0,1,0, 8191,8'hAA),
      mk(1,0,0,    0,8'hFF), mk(1,0,0, 8031,8'h80), mk(1,0,0,-8031,8'h00),
      mk(1,0,0,   99,8'hDF), mk(1,0,0,-1023,8'h2F), mk(1,0,0,   30,8'hF0),
      mk(1,0,0,  107,8'hDE),
      mk(1,0,1,  103,8'hDF), mk(1,0,1,  103,8'hDE), mk(1,0,1, 7903,8'h80),
      mk(1,0,1,-7903,8'h00),
      mk(1,1,0,    2,8'hD5), mk(1,1,0,   -2,8'h55), mk(1,1,0, 8064,8'hAA),
      mk(1,1,0,-8064,8'h2A), mk(1,1,0,  102,8'hCC), mk(1,1,0,-1008,8'h1A),
      mk(1,1,1,  100,8'hCC), mk(1,1,1,  100,8'hCD), mk(1,1,1,    4,8'hD5),
      mk(1,1,1, 7936,8'hAA)
   };

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk14(string req, logic signed [13:0] act, logic signed [13:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(bit law);
      @(negedge clk);
      law_sel = law;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk8("R1 idle code", tx_code, law ? 8'hD5 : 8'hFF);
      chk14("R1 rx reset", rx_lin, 14'sd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic enc(bit law, int lin);
      law_sel = law;
      tx_lin = 14'(lin);
      tx_strobe = 1'b1;
      @(negedge clk);
      tx_strobe = 1'b0;
   endtask

   task automatic dec(bit law, bit half, logic [7:0] code);
      law_sel = law;
      rx_half_lsb = half;
      rx_code = code;
      rx_strobe = 1'b1;
      @(negedge clk);
      rx_strobe = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [24:0] v;
         string req;
         v = VEC[i];
         if (!v[24]) begin
            req = v[23] ? "R4 a-law encode" : "R2 mu-law encode";
            enc(v[23], int'($signed(v[21:8])));
            chk8(req, tx_code, v[7:0]);
         end else begin
            if (v[22]) req = "R9 half-step decode";
            else req = v[23] ? "R8 a-law decode" : "R7 mu-law decode";
            dec(v[23], v[22], v[7:0]);
            chk14(req, rx_lin, $signed(v[21:8]));
         end
      end

      // R3 mu-law clipping
      enc(1'b0, 8191);  chk8("R3 mu clip top", tx_code, 8'h80);
      enc(1'b0, 8159);  chk8("R3 mu clip edge", tx_code, 8'h80);
      enc(1'b0, 8158);  chk8("R3 mu clip point", tx_code, 8'h80);
      enc(1'b0, -8192); chk8("R3 mu clip bottom", tx_code, 8'h00);
      // R5 a-law full scale
      enc(1'b1, -8192); chk8("R5 a-law negative full", tx_code, 8'h2A);
      enc(1'b1, 8191);  chk8("R5 a-law positive full", tx_code, 8'hAA);

      // R11 same sample under both laws
      enc(1'b0, 1000); chk8("R11 mu-law 1000", tx_code, 8'hAF);
      enc(1'b1, 1000); chk8("R11 a-law 1000", tx_code, 8'h9A);

      // R6 hold without strobe
      enc(1'b0, 100);
      tx_lin = -14'sd1000;
      repeat (3) @(negedge clk);
      chk8("R6 tx hold", tx_code, 8'hDF);

      // R10 hold without strobe
      dec(1'b0, 1'b0, 8'hDF);
      rx_code = 8'h00;
      rx_half_lsb = 1'b1;
      repeat (3) @(negedge clk);
      chk14("R10 rx hold", rx_lin, 14'sd99);

      do_reset(1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule